// File: doc/BRIEF.md
# Coalescing Interrupt Controller with Watermark Hysteresis

This block collects interrupt causes for a packet interface device and drives one level interrupt line to the host. The receive and transmit engines raise single-cycle event pulses, one bit per cause. Each pulse sets a sticky status bit. A mask register chooses which causes may reach the line, and a global enable bit gates the line as a whole. The host reaches five registers through a simple one-access-per-cycle port. Reading the status register returns its value and clears it. Writing the status register clears only the bits written as one.

Delivery is coalesced. A non-urgent cause arms a deadline a programmable number of cycles ahead. An urgent cause, or a delay of zero, asserts the line on the next edge. A pending deadline can be pulled earlier but is never pushed later. The receive-high and transmit-low watermark causes carry hysteresis. Each one is delivered only once per episode: after a receive-empty event or a transmit-full event respectively.

Top module: `irq_coalesce_ctl`

## Requirements
- R1: `irq_o` is high only while the enable bit (address 0, bit 0) is set and status AND mask is nonzero. It rises only when a delivery happens, never merely because status holds bits.
- R2: Event bit i on `evt_i` sets status bit i, and the bit stays set until it is cleared. Cause positions: 0 soft, 1 receive-DMA, 2 receive-packet, 3 receive-high, 4 receive-empty, 5 transmit-DMA, 6 transmit-packet, 7 transmit-low, 8 transmit-full. Bits 9 and above are reserved.
- R3: A read of address 2 returns the status and clears every bit on that edge. A write to address 2 clears only the bits set in the write data.
- R4: An event pulse or a status write that touches a reserved bit raises `err_o` for one cycle after the sampling edge. Reserved status bits always read as zero.
- R5: Receive-high (bit 3) is delivered only if a receive-empty event (bit 4) has occurred since it was last delivered. Each delivery consumes that arming. Arming is clear after reset.
- R6: Transmit-low (bit 7) is delivered only if a transmit-full event (bit 8) has occurred since it was last delivered. Each delivery consumes that arming. Arming is clear after reset.
- R7: A delivery that includes an urgent cause (by default soft, bit 0), or that happens while the delay register (address 4) is zero, raises `irq_o` on the sampling edge. Any other delivery raises it the delay value in cycles later.
- R8: While a deadline is pending, a new delivery with a later deadline leaves it unchanged. A new delivery with an earlier deadline replaces it.
- R9: A clear that leaves status AND mask at zero drops `irq_o` on that edge and cancels any pending deadline.
- R10: A mask write (address 3) with a new value raises the line at once if unmasked status remains. If no unmasked status remains, it drops the line. Writing the current value again changes nothing.
- R11: After reset, status is 0, enable is 0, the delay is 4 and the mask is 0x008D (soft, receive-packet, receive-high, transmit-low). Writing bit 0 of the command address (1) posts the soft cause.
- R12: Clearing the enable bit drops the line and cancels any pending deadline. Setting the enable bit while unmasked status is present raises the line at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | CAUSE_W | Single-cycle cause pulses from the engines |
| hst_sel | input | 1 | Host access strobe, one access per cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 3 | Register select: 0 config, 1 command, 2 status, 3 mask, 4 delay |
| hst_wdata | input | CAUSE_W | Host write data |
| hst_rdata | output | CAUSE_W | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Interrupt line to the host |
| err_o | output | 1 | One-cycle pulse on a reserved-bit access |

## Verification
The assertions assume that the host makes at most one access per cycle, and that event pulses and host accesses are sampled only on rising edges. The urgent-delivery and same-mask properties also assume that no host access competes in the cycle they inspect. The bench drives every input on the falling edge. It issues each register access as one isolated strobe cycle and lowers it again before the next access. Event pulses stay one cycle wide, and reserved bits are driven only in the dedicated error steps.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;

   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_CFG = 3'd0,
      RA_CMD = 3'd1,
      RA_STS = 3'd2,
      RA_MSK = 3'd3,
      RA_DLY = 3'd4
   } reg_addr_e;

   // cause bit positions
   localparam int unsigned CZ_SOFT  = 0;
   localparam int unsigned CZ_RXDMA = 1;
   localparam int unsigned CZ_RXPKT = 2;
   localparam int unsigned CZ_RXHI  = 3;
   localparam int unsigned CZ_RXEMP = 4;
   localparam int unsigned CZ_TXDMA = 5;
   localparam int unsigned CZ_TXPKT = 6;
   localparam int unsigned CZ_TXLO  = 7;
   localparam int unsigned CZ_TXFUL = 8;
   localparam int unsigned CZ_COUNT = 9;

endpackage

// File: rtl/irq_host_regs.sv
module irq_host_regs
   import irq_coalesce_pkg::*;
#(
   parameter int unsigned            CAUSE_W   = 16,
   parameter int unsigned            DLY_W     = 16,
   parameter logic [DLY_W-1:0]       DELAY_RST = 4,
   parameter logic [CAUSE_W-1:0]     MASK_RST  = '0,
   parameter logic [CAUSE_W-1:0]     RSVD      = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                wr,
   input  logic [REG_AW-1:0]   addr,
   input  logic [CAUSE_W-1:0]  wdata,
   input  logic [CAUSE_W-1:0]  status_q,
   output logic [CAUSE_W-1:0]  rdata,
   output logic [CAUSE_W-1:0]  mask_q,
   output logic [CAUSE_W-1:0]  mask_d,
   output logic                en_q,
   output logic                en_d,
   output logic [DLY_W-1:0]    dly_q,
   output logic [CAUSE_W-1:0]  clr_vec,
   output logic                soft_post,
   output logic                reeval,
   output logic                w1c_bad
);

   logic acc_rd, acc_wr;
   logic wr_cfg, wr_cmd, wr_sts, wr_msk, wr_dly, rd_sts;
   logic [CAUSE_W-1:0] dly_ext;

   assign acc_rd = sel & ~wr;
   assign acc_wr = sel &  wr;
   assign wr_cfg = acc_wr && (addr == RA_CFG);
   assign wr_cmd = acc_wr && (addr == RA_CMD);
   assign wr_sts = acc_wr && (addr == RA_STS);
   assign wr_msk = acc_wr && (addr == RA_MSK);
   assign wr_dly = acc_wr && (addr == RA_DLY);
   assign rd_sts = acc_rd && (addr == RA_STS);

   generate
      if (CAUSE_W > DLY_W) begin : g_dly_pad
         assign dly_ext = {{(CAUSE_W-DLY_W){1'b0}}, dly_q};
      end else begin : g_dly_flat
         assign dly_ext = dly_q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (acc_rd) begin
         case (addr)
            RA_CFG:  rdata[0] = en_q;
            RA_STS:  rdata    = status_q;
            RA_MSK:  rdata    = mask_q;
            RA_DLY:  rdata    = dly_ext;
            default: rdata    = '0;
         endcase
      end
   end

   assign mask_d    = wr_msk ? wdata : mask_q;
   assign en_d      = wr_cfg ? wdata[0] : en_q;
   assign soft_post = wr_cmd & wdata[0];
   assign reeval    = (wr_msk && (wdata != mask_q)) || (wr_cfg && wdata[0] && !en_q);
   assign w1c_bad   = wr_sts && |(wdata & RSVD);

   always_comb begin
      if (rd_sts)      clr_vec = '1;
      else if (wr_sts) clr_vec = wdata;
      else             clr_vec = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= MASK_RST;
         en_q   <= 1'b0;
         dly_q  <= DELAY_RST;
      end else begin
         mask_q <= mask_d;
         en_q   <= en_d;
         if (wr_dly) dly_q <= wdata[DLY_W-1:0];
      end
   end

endmodule

// File: rtl/irq_cause_qual.sv
module irq_cause_qual
   import irq_coalesce_pkg::*;
#(
   parameter int unsigned        CAUSE_W     = 16,
   parameter bit                 HYST_EN     = 1'b1,
   parameter logic [CAUSE_W-1:0] URGENT_MASK = 1,
   parameter logic [CAUSE_W-1:0] RSVD        = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CAUSE_W-1:0]  evt,
   input  logic                soft_post,
   input  logic [CAUSE_W-1:0]  clr_vec,
   input  logic [CAUSE_W-1:0]  mask_d,
   input  logic                w1c_bad,
   output logic [CAUSE_W-1:0]  status_q,
   output logic [CAUSE_W-1:0]  status_d,
   output logic                post_del,
   output logic                post_urg,
   output logic                err_q,
   output logic                rx_armed,
   output logic                tx_armed
);

   logic [CAUSE_W-1:0] soft_vec, set_vec, qual, del_vec;
   logic               post_cyc;

   always_comb begin
      soft_vec          = '0;
      soft_vec[CZ_SOFT] = soft_post;
   end

   assign set_vec  = (evt | soft_vec) & ~RSVD;
   assign post_cyc = |set_vec;
   assign status_d = (status_q & ~clr_vec) | set_vec;
   assign del_vec  = status_d & mask_d & qual;
   assign post_del = post_cyc && (|del_vec);
   assign post_urg = |(del_vec & URGENT_MASK);

   generate
      if (HYST_EN) begin : g_hyst
         logic rx_arm_q, tx_arm_q;
         logic rx_take, tx_take;

         always_comb begin
            qual          = '1;
            qual[CZ_RXHI] = rx_arm_q;
            qual[CZ_TXLO] = tx_arm_q;
         end

         assign rx_take = post_cyc & del_vec[CZ_RXHI];
         assign tx_take = post_cyc & del_vec[CZ_TXLO];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rx_arm_q <= 1'b0;
               tx_arm_q <= 1'b0;
            end else begin
               rx_arm_q <= (rx_arm_q & ~rx_take) | set_vec[CZ_RXEMP];
               tx_arm_q <= (tx_arm_q & ~tx_take) | set_vec[CZ_TXFUL];
            end
         end

         assign rx_armed = rx_arm_q;
         assign tx_armed = tx_arm_q;
      end else begin : g_plain
         assign qual     = '1;
         assign rx_armed = 1'b1;
         assign tx_armed = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         err_q    <= 1'b0;
      end else begin
         status_q <= status_d;
         err_q    <= (|(evt & RSVD)) | w1c_bad;
      end
   end

endmodule

// File: rtl/irq_deadline.sv
module irq_deadline #(
   parameter int unsigned DLY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_d,
   input  logic              live_d,
   input  logic              post_del,
   input  logic              post_urg,
   input  logic              reeval,
   input  logic [DLY_W-1:0]  dly_q,
   output logic              irq_q,
   output logic              pend_q,
   output logic [DLY_W-1:0]  cnt_q
);

   logic             irq_n, pend_n, imm;
   logic [DLY_W-1:0] cnt_n;

   assign imm = (post_del && (post_urg || (dly_q == '0))) || reeval;

   always_comb begin
      irq_n  = irq_q;
      pend_n = pend_q;
      cnt_n  = cnt_q;
      if (!en_d || !live_d) begin
         irq_n  = 1'b0;
         pend_n = 1'b0;
         cnt_n  = '0;
      end else begin
         if (pend_q) begin
            if (cnt_q == DLY_W'(1)) begin
               irq_n  = 1'b1;
               pend_n = 1'b0;
            end else begin
               cnt_n = cnt_q - DLY_W'(1);
            end
         end
         if (imm) begin
            irq_n  = 1'b1;
            pend_n = 1'b0;
         end else if (post_del) begin
            if (!pend_n || (dly_q < cnt_n)) begin
               pend_n = 1'b1;
               cnt_n  = dly_q;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         irq_q  <= irq_n;
         pend_q <= pend_n;
         cnt_q  <= cnt_n;
      end
   end

endmodule

// File: rtl/irq_coalesce_ctl.sv
module irq_coalesce_ctl
   import irq_coalesce_pkg::*;
#(
   parameter int unsigned        CAUSE_W     = 16,
   parameter int unsigned        DLY_W       = 16,
   parameter logic [DLY_W-1:0]   DELAY_RST   = 4,
   parameter logic [CAUSE_W-1:0] URGENT_MASK = 1,
   parameter bit                 HYST_EN     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] evt_i,
   input  logic               hst_sel,
   input  logic               hst_wr,
   input  logic [2:0]         hst_addr,
   input  logic [CAUSE_W-1:0] hst_wdata,
   output logic [CAUSE_W-1:0] hst_rdata,
   output logic               irq_o,
   output logic               err_o
);

   localparam logic [CAUSE_W-1:0] KNOWN_MASK = CAUSE_W'((1 << CZ_COUNT) - 1);
   localparam logic [CAUSE_W-1:0] RSVD_MASK  = ~KNOWN_MASK;
   localparam logic [CAUSE_W-1:0] MASK_RST   =
      CAUSE_W'((1 << CZ_SOFT) | (1 << CZ_RXPKT) | (1 << CZ_RXHI) | (1 << CZ_TXLO));

   generate
      if (CAUSE_W < CZ_COUNT) begin : g_bad_cause_w
         $error("CAUSE_W must hold all defined causes");
      end
      if (DLY_W < 2 || DLY_W > CAUSE_W) begin : g_bad_dly_w
         $error("DLY_W must lie between 2 and CAUSE_W");
      end
      if ((URGENT_MASK & RSVD_MASK) != '0) begin : g_bad_urgent
         $error("URGENT_MASK names a reserved cause");
      end
   endgenerate

   logic [CAUSE_W-1:0] mask_q, mask_d, status_q, status_d, clr_vec;
   logic               en_q, en_d, soft_post, reeval, w1c_bad;
   logic               post_del, post_urg, rx_armed, tx_armed;
   logic               pend_q;
   logic [DLY_W-1:0]   dly_q, cnt_q;

   irq_host_regs #(
      .CAUSE_W(CAUSE_W), .DLY_W(DLY_W), .DELAY_RST(DELAY_RST),
      .MASK_RST(MASK_RST), .RSVD(RSVD_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(hst_sel), .wr(hst_wr), .addr(hst_addr),
      .wdata(hst_wdata), .status_q(status_q), .rdata(hst_rdata),
      .mask_q(mask_q), .mask_d(mask_d), .en_q(en_q), .en_d(en_d),
      .dly_q(dly_q), .clr_vec(clr_vec), .soft_post(soft_post),
      .reeval(reeval), .w1c_bad(w1c_bad)
   );

   irq_cause_qual #(
      .CAUSE_W(CAUSE_W), .HYST_EN(HYST_EN),
      .URGENT_MASK(URGENT_MASK), .RSVD(RSVD_MASK)
   ) u_qual (
      .clk(clk), .rst_n(rst_n), .evt(evt_i), .soft_post(soft_post),
      .clr_vec(clr_vec), .mask_d(mask_d), .w1c_bad(w1c_bad),
      .status_q(status_q), .status_d(status_d), .post_del(post_del),
      .post_urg(post_urg), .err_q(err_o), .rx_armed(rx_armed),
      .tx_armed(tx_armed)
   );

   irq_deadline #(
      .DLY_W(DLY_W)
   ) u_dl (
      .clk(clk), .rst_n(rst_n), .en_d(en_d),
      .live_d(|(status_d & mask_d)), .post_del(post_del),
      .post_urg(post_urg), .reeval(reeval), .dly_q(dly_q),
      .irq_q(irq_o), .pend_q(pend_q), .cnt_q(cnt_q)
   );

endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
   parameter int unsigned        CAUSE_W = 16,
   parameter int unsigned        DLY_W   = 16,
   parameter logic [CAUSE_W-1:0] RSVD    = '0,
   parameter logic [CAUSE_W-1:0] URGENT  = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CAUSE_W-1:0] evt_i,
   input logic               hst_sel,
   input logic               hst_wr,
   input logic [2:0]         hst_addr,
   input logic [CAUSE_W-1:0] hst_wdata,
   input logic               irq_o,
   input logic               err_o,
   input logic               en_q,
   input logic [CAUSE_W-1:0] mask_q,
   input logic [CAUSE_W-1:0] status_q,
   input logic               pend_q,
   input logic [DLY_W-1:0]   cnt_q
);

   // R1
   line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (en_q && ((status_q & mask_q) != '0)));

   // R4
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & RSVD) == '0);

   // R4
   rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & RSVD) != '0) |=> err_o);

   // R7
   urgent_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hst_sel && en_q && ((evt_i & URGENT & mask_q) != '0)) |=> irq_o);

   // R8
   deadline_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && $past(pend_q)) |-> (cnt_q < $past(cnt_q)));

   // R9
   read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_sel && !hst_wr && hst_addr == 3'd2 && evt_i == '0) |=> (!irq_o && !pend_q));

   // R10
   same_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_sel && hst_wr && hst_addr == 3'd3 && hst_wdata == mask_q &&
       evt_i == '0 && !irq_o && !(pend_q && cnt_q == DLY_W'(1))) |=> !irq_o);

   // R12
   disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_sel && hst_wr && hst_addr == 3'd0 && !hst_wdata[0]) |=> (!irq_o && !pend_q));

endmodule

bind irq_coalesce_ctl irq_coalesce_chk #(
   .CAUSE_W(CAUSE_W), .DLY_W(DLY_W), .RSVD(RSVD_MASK), .URGENT(URGENT_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .hst_sel(hst_sel), .hst_wr(hst_wr),
   .hst_addr(hst_addr), .hst_wdata(hst_wdata), .irq_o(irq_o), .err_o(err_o),
   .en_q(en_q), .mask_q(mask_q), .status_q(status_q), .pend_q(pend_q),
   .cnt_q(cnt_q)
);

// File: tb/sim_irq_coalesce_ctl.sv
`timescale 1ns/1ps
module sim_irq_coalesce_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt_i = '0;
   logic        hst_sel = 1'b0;
   logic        hst_wr = 1'b0;
   logic [2:0]  hst_addr = '0;
   logic [15:0] hst_wdata = '0;
   logic [15:0] hst_rdata;
   logic        irq_o, err_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   bit running = 0;

   always #4 clk = ~clk;

   irq_coalesce_ctl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .hst_sel(hst_sel),
      .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .hst_rdata(hst_rdata), .irq_o(irq_o), .err_o(err_o)
   );

   // ---------------- behavioural reference model ----------------
   int m_sts, m_mask, m_dly, m_cnt;
   bit m_en, m_rxa, m_txa, m_pend, m_irq, m_err;
   int s_set, s_clr, s_nsts, s_nmask, s_del;
   bit s_nen, s_kick, s_post, s_bad;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sts = 0; m_mask = 'h8D; m_dly = 4; m_cnt = 0;
         m_en = 0; m_rxa = 0; m_txa = 0; m_pend = 0; m_irq = 0; m_err = 0;
      end else begin
         s_set = int'(evt_i) & 'h1FF;
         if (hst_sel && hst_wr && hst_addr == 1 && hst_wdata[0]) s_set = s_set | 1;
         s_bad = ((int'(evt_i) & 'hFE00) != 0) ||
                 (hst_sel && hst_wr && hst_addr == 2 && ((int'(hst_wdata) & 'hFE00) != 0));
         s_clr = 0;
         if (hst_sel && !hst_wr && hst_addr == 2) s_clr = 'hFFFF;
         if (hst_sel && hst_wr && hst_addr == 2) s_clr = int'(hst_wdata);
         s_nsts = (m_sts & ~s_clr) | s_set;
         s_nmask = (hst_sel && hst_wr && hst_addr == 3) ? int'(hst_wdata) : m_mask;
         s_nen = (hst_sel && hst_wr && hst_addr == 0) ? hst_wdata[0] : m_en;
         s_kick = (hst_sel && hst_wr && hst_addr == 3 && int'(hst_wdata) != m_mask) ||
                  (hst_sel && hst_wr && hst_addr == 0 && hst_wdata[0] && !m_en);
         s_del = s_nsts & s_nmask;
         if (!m_rxa) s_del = s_del & ~8;
         if (!m_txa) s_del = s_del & ~'h80;
         s_post = (s_set != 0) && (s_del != 0);
         if (!s_nen || (s_nsts & s_nmask) == 0) begin
            m_irq = 0; m_pend = 0; m_cnt = 0;
         end else begin
            if (m_pend) begin
               if (m_cnt == 1) begin m_irq = 1; m_pend = 0; end
               else m_cnt = m_cnt - 1;
            end
            if ((s_post && ((s_del & 1) != 0 || m_dly == 0)) || s_kick) begin
               m_irq = 1; m_pend = 0;
            end else if (s_post && (!m_pend || m_dly < m_cnt)) begin
               m_pend = 1; m_cnt = m_dly;
            end
         end
         if (s_set != 0 && (s_del & 8) != 0) m_rxa = 0;
         if ((s_set & 'h10) != 0) m_rxa = 1;
         if (s_set != 0 && (s_del & 'h80) != 0) m_txa = 0;
         if ((s_set & 'h100) != 0) m_txa = 1;
         m_sts = s_nsts; m_mask = s_nmask; m_en = s_nen; m_err = s_bad;
         if (hst_sel && hst_wr && hst_addr == 4) m_dly = int'(hst_wdata);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model (R1 line, R4 error pulse)
   always @(negedge clk) begin
      if (running) begin
         chk("R1 line vs model", int'(irq_o), int'(m_irq));
         chk("R4 err vs model", int'(err_o), int'(m_err));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hw(input int a, input int d);
      @(negedge clk);
      hst_sel = 1; hst_wr = 1; hst_addr = 3'(a); hst_wdata = 16'(d);
      @(negedge clk);
      hst_sel = 0; hst_wr = 0;
   endtask

   task automatic hr(input int a, input string tag, input int exp);
      @(negedge clk);
      hst_sel = 1; hst_wr = 0; hst_addr = 3'(a);
      #1 chk(tag, int'(hst_rdata), exp);
      @(negedge clk);
      hst_sel = 0;
   endtask

   task automatic ev(input int bits);
      @(negedge clk);
      evt_i = 16'(bits);
      @(negedge clk);
      evt_i = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      running = 1;
      // R11 reset state
      chk("R11 irq after reset", int'(irq_o), 0);
      hr(3, "R11 mask reset", 'h8D);
      hr(2, "R11 status reset", 0);
      hr(0, "R11 enable reset", 0);
      hr(4, "R11 delay reset", 4);

      // R1 disabled: soft via command sets status but no line
      hw(1, 1);
      chk("R1 no line while disabled", int'(irq_o), 0);
      hr(2, "R11 command posts soft", 1);
      hw(0, 1);

      // R7 urgent soft cause
      hw(1, 1);
      chk("R7 urgent immediate", int'(irq_o), 1);
      hr(2, "R3 read returns status", 1);
      chk("R9 read-clear drops line", int'(irq_o), 0);
      hr(2, "R3 status cleared by read", 0);

      // R7 delayed delivery with delay 4
      ev('h4);
      chk("R7 not yet", int'(irq_o), 0);
      idle(3);
      chk("R7 one cycle before deadline", int'(irq_o), 0);
      idle(1);
      chk("R7 at deadline", int'(irq_o), 1);
      // R2 sticky accumulation, R3 write-one-to-clear
      ev('h2); ev('h20);
      hw(2, 'h4);
      chk("R9 w1c drops line", int'(irq_o), 0);
      hr(2, "R2 sticky bits remain", 'h22);

      // R8 earlier deadline replaces pending one
      hw(4, 10);
      ev('h4);
      hw(4, 2);
      ev('h4);
      idle(1);
      chk("R8 earlier not yet", int'(irq_o), 0);
      idle(1);
      chk("R8 earlier replaces", int'(irq_o), 1);
      hw(2, 'h4);
      // R8 later deadline ignored
      hw(4, 6);
      ev('h4);
      hw(4, 30);
      ev('h4);
      idle(1);
      chk("R8 later ignored not yet", int'(irq_o), 0);
      idle(1);
      chk("R8 later ignored fires", int'(irq_o), 1);
      hw(2, 'h4);

      // R9 clear cancels pending deadline
      hw(4, 6);
      ev('h4);
      hw(2, 'h4);
      idle(8);
      chk("R9 pending cancelled", int'(irq_o), 0);

      // R10 mask writes
      hw(4, 20);
      ev('h4);
      hw(3, 'h8D);
      idle(2);
      chk("R10 same mask no effect", int'(irq_o), 0);
      hw(3, 'h4);
      chk("R10 new mask posts now", int'(irq_o), 1);
      hw(3, 'h20);
      chk("R10 mask hides all drops", int'(irq_o), 0);
      hw(3, 'h8D);
      hw(2, 'hFFFF);
      hr(2, "R3 all cleared", 0);

      // R5 receive-high hysteresis
      hw(4, 0);
      ev('h8);
      chk("R5 unarmed rx-high held", int'(irq_o), 0);
      ev('h10);
      chk("R5 rx-empty arms only", int'(irq_o), 0);
      ev('h8);
      chk("R5 armed rx-high delivers", int'(irq_o), 1);
      hr(2, "R5 status", 'h18);
      ev('h8);
      chk("R5 arming consumed", int'(irq_o), 0);
      hr(2, "R5 status again", 'h8);

      // R6 transmit-low hysteresis
      ev('h80);
      chk("R6 unarmed tx-low held", int'(irq_o), 0);
      ev('h100);
      chk("R6 tx-full arms only", int'(irq_o), 0);
      ev('h80);
      chk("R6 armed tx-low delivers", int'(irq_o), 1);
      hr(2, "R6 status", 'h180);
      ev('h80);
      chk("R6 arming consumed", int'(irq_o), 0);
      hr(2, "R6 status again", 'h80);

      // R4 reserved bits
      ev('h1000);
      chk("R4 reserved event flags", int'(err_o), 1);
      hr(2, "R4 reserved bit not stored", 0);
      hw(2, 'h0200);
      chk("R4 reserved clear flags", int'(err_o), 1);
      idle(1);
      chk("R4 flag is a pulse", int'(err_o), 0);

      // R12 enable control
      hw(4, 5);
      ev('h4);
      hw(0, 0);
      idle(8);
      chk("R12 disable cancels", int'(irq_o), 0);
      hw(0, 1);
      chk("R12 enable posts now", int'(irq_o), 1);
      hw(2, 'h4);
      chk("R12 cleared", int'(irq_o), 0);

      idle(4);
      running = 0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule